// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block gathers up to 32 interrupt lines for a processor core. Each line has a fixed priority level from 1 upward and a fixed trigger type, level or edge. Both are set by parameters. The block holds a pending word and an enable word. The core supplies its current masking level. From these the block reports the highest priority level that has a line both pending and enabled and that lies strictly above the masking level. It also raises a request line to the core whenever such a level exists.

Level-type lines track their input, so the pending bit drops when the line drops. Edge-type lines latch on a rising input. They stay latched until the core acknowledges them through a write-one-to-clear port. The enable word is loaded through a single write strobe. Lines whose index is at or above the configured line count are never wired to anything inside the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pending word, the enable word, the reported level and the request are all zero.
- R2: A line whose index is at or above NUM_IRQ (default 24) has no effect. Its pending bit stays 0 and it never contributes to the request.
- R3: A level-type line sets its pending bit while the input is 1 and clears it when the input returns to 0.
- R4: An edge-type line sets its pending bit on a 0-to-1 input change. The bit stays set after the input falls.
- R5: Writing ack_data with ack_wr high clears every edge-type pending bit whose ack_data bit is 1. A rising input on the same cycle wins and leaves the bit set. The acknowledge has no effect on level-type bits.
- R6: The enable word takes en_wdata when en_wr is high. Only bits set in both the pending word and the enable word are candidates. A pending bit that is disabled does not raise the request.
- R7: The reported level is the highest level, among 1..NUM_LVL, that holds at least one candidate and is strictly greater than mask_lvl. The request is 1 whenever such a level exists.
- R8: When no level above mask_lvl holds a candidate, the reported level is 0 and the request is 0. This includes the case where candidates exist only at or below mask_lvl.
- R9: The pending word, the enable word, the reported level and the request all reflect a change on irq_in, ack, en_wr or mask_lvl at the first rising clock edge after it.
- R10: With the default parameters, line i has level (i mod 7) + 1. Line i is edge-type when bit 1 of i is 1 (EDGE_MASK = 0xCCCCCCCC) and level-type otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt lines, one bit per source |
| en_wr | input | 1 | Load strobe for the enable word |
| en_wdata | input | 32 | New enable word |
| ack_wr | input | 1 | Acknowledge strobe |
| ack_data | input | 32 | Write-one-to-clear mask for edge-type pending bits |
| mask_lvl | input | 3 | Core's current masking level |
| pend_o | output | 32 | Pending word |
| enable_o | output | 32 | Enable word |
| irq_lvl_o | output | 3 | Highest qualifying level, 0 when none |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
All results are due exactly one clock edge after the stimulus. The arbitration works on the next-state pending and enable words, so no second register stage adds latency. The bench changes inputs on the falling edge and compares the pending word, level and request on the following falling edge, after the one rising edge between them has taken effect. The vector table and the per-line sweep therefore hold only one-cycle expectations. Reset behaviour is compared both while reset is held and after a mid-run reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    parameter int IRQ_W = 32;
    parameter int LVL_W = 3;

    typedef logic [IRQ_W-1:0]            irq_vec_t;
    typedef logic [LVL_W-1:0]            lvl_t;
    typedef logic [IRQ_W-1:0][LVL_W-1:0] lvl_map_t;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } grant_t;

    // Default assignment: line i goes to level (i mod n_lvl) + 1
    function automatic lvl_map_t spread_levels(int n_lvl);
        lvl_map_t m;
        for (int i = 0; i < IRQ_W; i++) begin
            m[i] = lvl_t'((i % n_lvl) + 1);
        end
        return m;
    endfunction

    function automatic irq_vec_t low_bits(int n);
        irq_vec_t v;
        for (int i = 0; i < IRQ_W; i++) begin
            v[i] = (i < n);
        end
        return v;
    endfunction

    function automatic irq_vec_t members_of(lvl_map_t m, lvl_t l);
        irq_vec_t v;
        for (int i = 0; i < IRQ_W; i++) begin
            v[i] = (m[i] == l);
        end
        return v;
    endfunction

    function automatic irq_vec_t members_above(lvl_map_t m, lvl_t l);
        irq_vec_t v;
        for (int i = 0; i < IRQ_W; i++) begin
            v[i] = (m[i] > l);
        end
        return v;
    endfunction

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int       NUM_IRQ   = 24,
    parameter irq_vec_t EDGE_MASK = 32'hCCCC_CCCC
) (
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_in,
    input  logic     ack_wr,
    input  irq_vec_t ack_data,
    output irq_vec_t pend_next,
    output irq_vec_t pend_q
);

    localparam irq_vec_t VALID   = low_bits(NUM_IRQ);
    localparam irq_vec_t EDGE_V  = EDGE_MASK & VALID;
    localparam irq_vec_t LEVEL_V = ~EDGE_MASK & VALID;

    irq_vec_t prev_q;
    irq_vec_t rise;
    irq_vec_t clr;

    assign rise = irq_in & ~prev_q;
    assign clr  = ack_wr ? ack_data : '0;

    // Level lines mirror the input; edge lines latch rises until acknowledged
    assign pend_next = (irq_in & LEVEL_V) | (((pend_q & ~clr) | rise) & EDGE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            pend_q <= pend_next;
            prev_q <= irq_in;
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int       NUM_LVL   = 7,
    parameter lvl_map_t LEVEL_MAP = spread_levels(7)
) (
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t cand,
    input  lvl_t     mask_lvl,
    output grant_t   grant_q
);

    logic [NUM_LVL:1] hit;
    grant_t           grant_d;

    for (genvar gl = 1; gl <= NUM_LVL; gl++) begin : g_lvl
        localparam irq_vec_t MEMB = members_of(LEVEL_MAP, lvl_t'(gl));
        assign hit[gl] = |(cand & MEMB);
    end

    // Keep the highest populated level that sits above the core's mask
    always_comb begin
        grant_d.lvl = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (hit[l] && (lvl_t'(l) > mask_lvl)) begin
                grant_d.lvl = lvl_t'(l);
            end
        end
        grant_d.req = (grant_d.lvl != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int       NUM_IRQ   = 24,
    parameter int       NUM_LVL   = 7,
    parameter lvl_map_t LEVEL_MAP = spread_levels(NUM_LVL),
    parameter irq_vec_t EDGE_MASK = 32'hCCCC_CCCC
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IRQ_W-1:0]        irq_in,
    input  logic                    en_wr,
    input  logic [IRQ_W-1:0]        en_wdata,
    input  logic                    ack_wr,
    input  logic [IRQ_W-1:0]        ack_data,
    input  logic [LVL_W-1:0]        mask_lvl,
    output logic [IRQ_W-1:0]        pend_o,
    output logic [IRQ_W-1:0]        enable_o,
    output logic [LVL_W-1:0]        irq_lvl_o,
    output logic                    irq_req_o
);

    irq_vec_t pend_next;
    irq_vec_t pend_q;
    irq_vec_t en_q;
    irq_vec_t en_next;
    grant_t   grant_q;

    irqc_pending #(
        .NUM_IRQ   (NUM_IRQ),
        .EDGE_MASK (EDGE_MASK)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .ack_wr    (ack_wr),
        .ack_data  (ack_data),
        .pend_next (pend_next),
        .pend_q    (pend_q)
    );

    assign en_next = en_wr ? en_wdata : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_next;
        end
    end

    // Arbitrate on next-state words so the grant lands with the state update
    irqc_arbiter #(
        .NUM_LVL   (NUM_LVL),
        .LEVEL_MAP (LEVEL_MAP)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .cand     (pend_next & en_next),
        .mask_lvl (mask_lvl),
        .grant_q  (grant_q)
    );

    assign pend_o    = pend_q;
    assign enable_o  = en_q;
    assign irq_lvl_o = grant_q.lvl;
    assign irq_req_o = grant_q.req;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int       NUM_IRQ   = 24,
    parameter lvl_map_t LEVEL_MAP = spread_levels(7),
    parameter irq_vec_t EDGE_MASK = 32'hCCCC_CCCC
) (
    input logic     clk,
    input logic     rst,
    input irq_vec_t irq_in,
    input logic     ack_wr,
    input irq_vec_t ack_data,
    input lvl_t     mask_lvl,
    input irq_vec_t pend_o,
    input irq_vec_t enable_o,
    input lvl_t     irq_lvl_o,
    input logic     irq_req_o
);

    localparam irq_vec_t VALID   = low_bits(NUM_IRQ);
    localparam irq_vec_t EDGE_V  = EDGE_MASK & VALID;
    localparam irq_vec_t LEVEL_V = ~EDGE_MASK & VALID;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (pend_o == '0 && enable_o == '0 && irq_lvl_o == '0 && !irq_req_o)); // R1

    AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pend_o & ~VALID) == '0); // R2

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_o & LEVEL_V) == ($past(irq_in) & LEVEL_V))); // R3

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(pend_o) & ~($past(ack_wr) ? $past(ack_data) : '0)
                          & EDGE_V & ~pend_o) == '0)); // R4

    AST_GRANT_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && irq_req_o) |-> (irq_lvl_o > $past(mask_lvl))); // R7

    AST_GRANT_BACKED: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> ((pend_o & enable_o & members_of(LEVEL_MAP, irq_lvl_o)) != '0)); // R7

    AST_GRANT_HIGHEST: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> ((pend_o & enable_o & members_above(LEVEL_MAP, irq_lvl_o)) == '0)); // R7

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !irq_req_o) |->
            (irq_lvl_o == '0 &&
             (pend_o & enable_o & members_above(LEVEL_MAP, $past(mask_lvl))) == '0)); // R8

endmodule

bind irq_prio_ctrl irqc_checker #(
    .NUM_IRQ   (NUM_IRQ),
    .LEVEL_MAP (LEVEL_MAP),
    .EDGE_MASK (EDGE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .ack_wr    (ack_wr),
    .ack_data  (ack_data),
    .mask_lvl  (mask_lvl),
    .pend_o    (pend_o),
    .enable_o  (enable_o),
    .irq_lvl_o (irq_lvl_o),
    .irq_req_o (irq_req_o)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        en_wr = 1'b0;
    logic [31:0] en_wdata = '0;
    logic        ack_wr = 1'b0;
    logic [31:0] ack_data = '0;
    logic [2:0]  mask_lvl = '0;
    logic [31:0] pend_o;
    logic [31:0] enable_o;
    logic [2:0]  irq_lvl_o;
    logic        irq_req_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit closed = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk (clk), .rst (rst), .irq_in (irq_in),
        .en_wr (en_wr), .en_wdata (en_wdata),
        .ack_wr (ack_wr), .ack_data (ack_data), .mask_lvl (mask_lvl),
        .pend_o (pend_o), .enable_o (enable_o),
        .irq_lvl_o (irq_lvl_o), .irq_req_o (irq_req_o)
    );

    typedef struct packed {
        logic [31:0] irq;
        logic        ewr;
        logic [31:0] en;
        logic        awr;
        logic [31:0] ack;
        logic [2:0]  msk;
        logic [31:0] x_pend;
        logic [2:0]  x_lvl;
        logic        x_req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0,        1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,  3'd0, 32'h0,      3'd0, 1'b0}, // R6 enable all
        '{32'h1,        1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h1,      3'd1, 1'b1}, // R3 R7
        '{32'h21,       1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h21,     3'd6, 1'b1}, // R7
        '{32'h21,       1'b0, 32'h0,         1'b0, 32'h0,  3'd6, 32'h21,     3'd0, 1'b0}, // R8 R9
        '{32'h21,       1'b0, 32'h0,         1'b0, 32'h0,  3'd5, 32'h21,     3'd6, 1'b1}, // R7 R9
        '{32'h1,        1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h1,      3'd1, 1'b1}, // R3
        '{32'h41,       1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h41,     3'd7, 1'b1}, // R4 R7
        '{32'h0,        1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h40,     3'd7, 1'b1}, // R4 R3
        '{32'h0,        1'b0, 32'h0,         1'b1, 32'h40, 3'd0, 32'h0,      3'd0, 1'b0}, // R5
        '{32'h4,        1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h4,      3'd3, 1'b1}, // R4
        '{32'h4,        1'b0, 32'h0,         1'b1, 32'h4,  3'd0, 32'h0,      3'd0, 1'b0}, // R5 held input
        '{32'h1,        1'b0, 32'h0,         1'b1, 32'h1,  3'd0, 32'h1,      3'd1, 1'b1}, // R5 level untouched
        '{32'h8,        1'b0, 32'h0,         1'b1, 32'h8,  3'd0, 32'h8,      3'd4, 1'b1}, // R5 rise wins
        '{32'h8,        1'b1, 32'hFFFF_FFF7, 1'b0, 32'h0,  3'd0, 32'h8,      3'd0, 1'b0}, // R6 R9
        '{32'hFF00_0008,1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h8,      3'd0, 1'b0}, // R2
        '{32'h0,        1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,  3'd0, 32'h8,      3'd4, 1'b1}, // R6
        '{32'h0,        1'b0, 32'h0,         1'b1, 32'h8,  3'd3, 32'h0,      3'd0, 1'b0}, // R5 R8
        '{32'h10_2000,  1'b0, 32'h0,         1'b0, 32'h0,  3'd7, 32'h10_2000,3'd0, 1'b0}, // R8
        '{32'h10_2000,  1'b0, 32'h0,         1'b0, 32'h0,  3'd6, 32'h10_2000,3'd7, 1'b1}, // R7 R9
        '{32'h0,        1'b0, 32'h0,         1'b0, 32'h0,  3'd0, 32'h0,      3'd0, 1'b0}  // R3
    };

    task automatic cmp(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!closed) begin
            closed = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        irq_in = 32'h0000_0044;
        en_wr = 1'b1; en_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cmp("R1", "pend", pend_o, 32'h0);
        cmp("R1", "enable", enable_o, 32'h0);
        cmp("R1", "req", {31'b0, irq_req_o}, 32'h0);
        irq_in = '0; en_wr = 1'b0; en_wdata = '0;
        rst = 1'b0;

        // Vector table, one row per cycle
        for (int r = 0; r < NV; r++) begin
            irq_in   = VECS[r].irq;
            en_wr    = VECS[r].ewr;
            en_wdata = VECS[r].en;
            ack_wr   = VECS[r].awr;
            ack_data = VECS[r].ack;
            mask_lvl = VECS[r].msk;
            @(negedge clk);
            cmp($sformatf("row%0d R9", r), "pend", pend_o, VECS[r].x_pend);
            cmp($sformatf("row%0d R7", r), "lvl", {29'b0, irq_lvl_o}, {29'b0, VECS[r].x_lvl});
            cmp($sformatf("row%0d R8", r), "req", {31'b0, irq_req_o}, {31'b0, VECS[r].x_req});
        end
        en_wr = 1'b0; ack_wr = 1'b0; mask_lvl = '0;

        // R10: per-line level and trigger type sweep
        for (int i = 0; i < 24; i++) begin
            logic [31:0] bitv;
            logic [31:0] after_fall;
            bitv = 32'h1 << i;
            after_fall = ((i >> 1) & 1) != 0 ? bitv : 32'h0;
            irq_in = bitv;
            @(negedge clk);
            cmp("R10", $sformatf("line%0d pend", i), pend_o, bitv);
            cmp("R10", $sformatf("line%0d lvl", i), {29'b0, irq_lvl_o}, (i % 7) + 1);
            irq_in = '0;
            @(negedge clk);
            cmp("R10", $sformatf("line%0d type", i), pend_o, after_fall);
            ack_wr = 1'b1; ack_data = 32'hFFFF_FFFF;
            @(negedge clk);
            ack_wr = 1'b0; ack_data = '0;
            cmp("R5", $sformatf("line%0d ack", i), pend_o, 32'h0);
        end

        // R2: every out-of-range line at once, all enabled
        irq_in = 32'hFF00_0000;
        @(negedge clk);
        cmp("R2", "pend", pend_o, 32'h0);
        cmp("R2", "req", {31'b0, irq_req_o}, 32'h0);
        irq_in = 32'h0;
        @(negedge clk);
        cmp("R2", "pend after fall", pend_o, 32'h0);

        // R1: mid-run reset clears a latched edge bit and the enables
        irq_in = 32'h4;
        @(negedge clk);
        cmp("R4", "latched", pend_o, 32'h4);
        irq_in = 32'h0;
        rst = 1'b1;
        @(negedge clk);
        cmp("R1", "pend", pend_o, 32'h0);
        cmp("R1", "enable", enable_o, 32'h0);
        cmp("R1", "lvl", {29'b0, irq_lvl_o}, 32'h0);
        cmp("R1", "req", {31'b0, irq_req_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1", "pend after release", pend_o, 32'h0);
        cmp("R6", "enable after release", enable_o, 32'h0);

        finish_run();
    end

endmodule